// File: doc/BRIEF.md
# Warp Lane-Mask Divergence Stack

This block tracks which of the 32 lanes of a warp are enabled while the warp runs through data-dependent branches. All lanes share one instruction stream, so a branch whose condition differs between lanes cannot fork the warp. Instead the lanes that take the branch run the first path alone, then the lanes that did not take it run the second path alone, and at the join point every lane that was enabled before the branch is enabled again. A divergent branch therefore costs the length of both paths together.

The sequencer signals three events: a branch with one condition bit per lane, the end of the current path, and the join point. The block answers with the active-lane mask that the lanes use to gate their register writes. Each branch saves the enclosing mask and the pending second-path mask on a stack of fixed depth, so branches can nest. Only one event is expected per cycle. If several arrive together, the join wins over the end of path, and the end of path wins over the branch.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the stack is empty and both error flags are 0.
- R2: On a branch with a free stack slot, the mask of the first path is the previous mask ANDed with the condition vector (bit i is lane i), so a lane that was disabled stays disabled.
- R3: An end-of-path event during the first path switches the mask to the pre-branch mask ANDed with the inverted condition.
- R4: A join event restores exactly the mask that was active before the matching branch and removes that stack entry.
- R5: If every active lane has a true condition, the first path runs with the unchanged mask and the end-of-path event leaves the mask as it is, because the second path is empty.
- R6: If no active lane has a true condition, the branch goes straight to the second-path mask, and a later end-of-path event has no effect.
- R7: Branches nest up to DEPTH levels, and the joins unwind them in reverse order.
- R8: A branch while DEPTH entries are held sets a sticky overflow flag, leaves the mask unchanged and pushes nothing.
- R9: A join while the stack is empty sets a sticky underflow flag and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | Branch event for this cycle |
| br_cond | input | LANES | Per-lane branch condition |
| path_end | input | 1 | The current path of the innermost branch has finished |
| reconv | input | 1 | Join point of the innermost branch |
| active_mask | output | LANES | Lanes enabled to write |
| ovf_err | output | 1 | Sticky: a branch was refused because the stack was full |
| udf_err | output | 1 | Sticky: a join arrived with an empty stack |

## Verification
The assertions take for granted that the sequencer raises at most one event per cycle. The same-cycle priority is defined, but the properties on the branch and the end of path only apply when their event is the only one raised. They also take for granted that reset leaves the mask all ones with an empty stack, which the bench sets up by holding reset for several cycles. Every stimulus raises a single event for one cycle and then leaves the inputs idle, so each response is checked against a known previous mask.

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic             path_end,
  input  logic             reconv,
  output logic [LANES-1:0] active_mask,
  output logic             ovf_err,
  output logic             udf_err
);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] saved_q [DEPTH];
  logic [LANES-1:0] pend_q  [DEPTH];
  logic [DEPTH-1:0] in_else_q;
  logic [SW-1:0]    sp_q;
  logic [IW-1:0]    wr_idx, rd_idx;
  logic [LANES-1:0] take_m, skip_m;
  logic             full, empty;

  assign full   = (sp_q == SW'(DEPTH));
  assign empty  = (sp_q == '0);
  assign wr_idx = IW'(sp_q);
  assign rd_idx = IW'(sp_q - 1'b1);
  assign take_m = active_mask & br_cond;
  assign skip_m = active_mask & ~br_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_mask <= '1;
      sp_q        <= '0;
      in_else_q   <= '0;
      ovf_err     <= 1'b0;
      udf_err     <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        saved_q[i] <= '0;
        pend_q[i]  <= '0;
      end
    end else if (reconv) begin
      if (empty) udf_err <= 1'b1;
      else begin
        active_mask <= saved_q[rd_idx];
        sp_q        <= sp_q - 1'b1;
      end
    end else if (path_end) begin
      if (!empty && !in_else_q[rd_idx]) begin
        in_else_q[rd_idx] <= 1'b1;
        if (pend_q[rd_idx] != '0) active_mask <= pend_q[rd_idx];
      end
    end else if (br_valid) begin
      if (full) ovf_err <= 1'b1;
      else begin
        saved_q[wr_idx]   <= active_mask;
        pend_q[wr_idx]    <= skip_m;
        in_else_q[wr_idx] <= (take_m == '0);
        active_mask       <= (take_m != '0) ? take_m : skip_m;
        sp_q              <= sp_q + 1'b1;
      end
    end
  end

  // R2
  branch_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !path_end && !reconv && !full |=> (active_mask & ~$past(active_mask)) == '0);
  // R3
  path_swap_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_end && !reconv && (active_mask != '0) |=>
      (active_mask == $past(active_mask)) || ((active_mask & $past(active_mask)) == '0));
  // R4
  empty_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> active_mask == '1);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !path_end && !reconv && full |=> ovf_err && $stable(active_mask));
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconv && empty |=> udf_err && $stable(active_mask));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SW'(DEPTH));
endmodule

// File: tb/simt_mask_stack_tb.sv
module simt_mask_stack_tb;
  localparam int LANES = 32;
  localparam int DEPTH = 4;
  localparam logic [1:0] OP_NONE = 2'd0, OP_BR = 2'd1, OP_END = 2'd2, OP_JOIN = 2'd3;
  localparam int NV = 21;

  // {op, cond, expected mask, requirement number}
  localparam logic [73:0] VEC [NV] = '{
    {OP_BR,   32'h0000FFFF, 32'h0000FFFF, 8'd2},  // R2 split halves
    {OP_END,  32'h0,        32'hFFFF0000, 8'd3},  // R3
    {OP_JOIN, 32'h0,        32'hFFFFFFFF, 8'd4},  // R4
    {OP_BR,   32'h00FF00FF, 32'h00FF00FF, 8'd2},  // R2
    {OP_BR,   32'h0F0F0F0F, 32'h000F000F, 8'd2},  // R2 nested, inactive lanes stay off
    {OP_END,  32'h0,        32'h00F000F0, 8'd3},  // R3
    {OP_JOIN, 32'h0,        32'h00FF00FF, 8'd4},  // R4
    {OP_END,  32'h0,        32'hFF00FF00, 8'd3},  // R3
    {OP_BR,   32'hFFFF0000, 32'hFF000000, 8'd7},  // R7 nested in second path
    {OP_END,  32'h0,        32'h0000FF00, 8'd7},  // R7
    {OP_JOIN, 32'h0,        32'hFF00FF00, 8'd7},  // R7
    {OP_JOIN, 32'h0,        32'hFFFFFFFF, 8'd4},  // R4
    {OP_BR,   32'hFFFFFFFF, 32'hFFFFFFFF, 8'd5},  // R5 uniform true
    {OP_END,  32'h0,        32'hFFFFFFFF, 8'd5},  // R5 empty second path
    {OP_JOIN, 32'h0,        32'hFFFFFFFF, 8'd5},  // R5
    {OP_BR,   32'hFFFF0000, 32'hFFFF0000, 8'd2},  // R2
    {OP_BR,   32'h0000FFFF, 32'hFFFF0000, 8'd6},  // R6 no active lane true
    {OP_END,  32'h0,        32'hFFFF0000, 8'd6},  // R6 end has no effect
    {OP_JOIN, 32'h0,        32'hFFFF0000, 8'd6},  // R6
    {OP_END,  32'h0,        32'h0000FFFF, 8'd3},  // R3
    {OP_JOIN, 32'h0,        32'hFFFFFFFF, 8'd4}   // R4
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 1'b0, path_end = 1'b0, reconv = 1'b0;
  logic [LANES-1:0] br_cond = '0;
  logic [LANES-1:0] active_mask;
  logic ovf_err, udf_err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
    .path_end(path_end), .reconv(reconv), .active_mask(active_mask),
    .ovf_err(ovf_err), .udf_err(udf_err));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] cond);
    @(negedge clk);
    br_valid = (op == OP_BR);
    path_end = (op == OP_END);
    reconv   = (op == OP_JOIN);
    br_cond  = cond;
    @(negedge clk);
    br_valid = 1'b0; path_end = 1'b0; reconv = 1'b0; br_cond = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {32'h0, active_mask}, {32'h0, 32'hFFFFFFFF});
    check("R1", {62'h0, ovf_err, udf_err}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][73:72], VEC[i][71:40]);
      check($sformatf("R%0d vec %0d", VEC[i][7:0], i), {32'h0, active_mask}, {32'h0, VEC[i][39:8]});
    end
    check("R9", {63'h0, udf_err}, 64'h0);

    // R7 fill the stack to DEPTH
    step(OP_BR, 32'h7FFFFFFF); check("R7", {32'h0, active_mask}, {32'h0, 32'h7FFFFFFF});
    step(OP_BR, 32'h3FFFFFFF);
    step(OP_BR, 32'h1FFFFFFF);
    step(OP_BR, 32'h0FFFFFFF); check("R7", {32'h0, active_mask}, {32'h0, 32'h0FFFFFFF});
    check("R8", {63'h0, ovf_err}, 64'h0);
    // R8 overflow
    step(OP_BR, 32'h00000001);
    check("R8", {63'h0, ovf_err}, 64'h1);
    check("R8", {32'h0, active_mask}, {32'h0, 32'h0FFFFFFF});
    // R4 unwind; refused branch must not have pushed
    step(OP_JOIN, 32'h0); check("R8", {32'h0, active_mask}, {32'h0, 32'h1FFFFFFF});
    step(OP_JOIN, 32'h0); check("R4", {32'h0, active_mask}, {32'h0, 32'h3FFFFFFF});
    step(OP_JOIN, 32'h0); check("R4", {32'h0, active_mask}, {32'h0, 32'h7FFFFFFF});
    step(OP_JOIN, 32'h0); check("R4", {32'h0, active_mask}, {32'h0, 32'hFFFFFFFF});
    // R9 underflow
    step(OP_JOIN, 32'h0);
    check("R9", {63'h0, udf_err}, 64'h1);
    check("R9", {32'h0, active_mask}, {32'h0, 32'hFFFFFFFF});
    step(OP_NONE, 32'h0);
    check("R8", {62'h0, ovf_err, udf_err}, 64'h3);
    // R1 reset clears the flags
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    check("R1", {62'h0, ovf_err, udf_err}, 64'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule